// File: doc/BRIEF.md
# Zero-overhead loop sequencer

This block steers the program counter of a 16-bit signal processor through short hardware loops, so that the loops cost no branch instructions. Each cycle it is given the address of the instruction being executed and that instruction's opcode. It returns three results for that instruction: the signed amount to add to the program counter, the resulting next address, and the number of cycles the instruction takes. It keeps four pieces of loop state: the first address of the loop body, the address just past the body, an iteration counter, and an optional return address.

A capture instruction opens a loop over the instructions that follow it. A replay instruction jumps back into the body captured most recently and runs it again. When the replay finishes, execution continues at the instruction after the replay. Ordinary instructions pass through unchanged, except when their sequential successor would be the loop end; in that case the block redirects the program counter itself. The datapath, the fetch memory and the storage of the loop instruction words all sit outside this block.

Top module: `loop_cache_seq`

## Requirements
- R1: An opcode whose bits 15:11 equal 5'b01110 is a loop instruction, with its count field in bits 10:7 and its repeat field in bits 6:0. Any other opcode passes through with the advance taken from `baseAdvance` and the cost taken from `baseCycles`, unless R4 or R5 redirects it.
- R2: A loop instruction with a nonzero count N is a capture. It sets the loop start to pc+1, the loop end to pc+N+1 and the counter to repeat+1. It advances by 1 and costs 1 cycle.
- R3: A loop instruction with count zero is a replay when the loop start is valid. It loads the counter with repeat+1, saves pc+1 as the return address, sets the next PC to the loop start, and costs 2 cycles.
- R4: When the sequential next address (pc plus the advance) equals a valid loop end and the counter is nonzero, the counter decrements and the next PC becomes the loop start. For a capture, the body therefore runs repeat+2 times in all.
- R5: When the sequential next address equals a valid loop end and the counter is zero, a valid saved return address becomes the next PC and is then invalidated. With no saved return address, execution falls through past the loop.
- R6: Reset sets the loop start, loop end and return address to the invalid marker 0xFFFF, and clears the counter.
- R7: A replay issued while the loop start is invalid has no effect. It advances by 1, costs 1 cycle and changes no state.
- R8: While `instValid` is low, no loop state changes. A loop that is stalled this way resumes exactly where it stopped.
- R9: `loopActive` is high exactly when the iteration counter is nonzero.
- R10: A two-word instruction whose sequential successor equals the loop end triggers the loop-back of R4 in the same way as a one-word instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | The instruction on `pc`/`opcode` executes this cycle |
| pc | input | 16 | Address of the executing instruction |
| opcode | input | 16 | First word of the executing instruction |
| baseAdvance | input | 2 | Word length of a non-loop instruction |
| baseCycles | input | 2 | Cycle cost of a non-loop instruction |
| pcAdvance | output | 16 | Signed amount to add to the program counter |
| nextPc | output | 16 | pc + pcAdvance |
| cycleCost | output | 2 | Cycles charged for this instruction |
| loopActive | output | 1 | Iteration counter is nonzero |

## Verification
The loop logic is exercised with several instruction streams, each chosen to separate particular behaviours:
- A multi-instruction capture with a stall in the middle. This distinguishes a correct count of body passes from an off-by-one count, and shows whether a stall wrongly consumes an iteration.
- A replay after the capture. This separates a return to the saved address from a plain fall-through.
- A one-instruction body, where the body instruction and the loop end are adjacent. This exposes confusion between the start and end comparisons.
- A full 15-instruction body stepped through with two-word instructions. This shows whether the end match uses the real advance or always assumes one word.
- A replay issued straight after reset. This checks that it is ignored while no loop start has been captured.

// File: rtl/loop_cache_pkg.sv
package loop_cache_pkg;

  // Strobes from the control decision logic to the loop state registers.
  typedef struct packed {
    logic loadDo;    // capture a new loop body
    logic loadRedo;  // replay the stored body and save the return address
    logic decCnt;    // one loop-back taken
    logic clrRet;    // saved return address consumed
  } loop_strobe_t;

endpackage

// File: rtl/loop_cache_regs.sv
module loop_cache_regs
  import loop_cache_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  loop_strobe_t       strobe,
  input  logic [PC_W-1:0]    pc,
  input  logic [NI_W-1:0]    niField,
  input  logic [K_W-1:0]     kField,
  output logic [PC_W-1:0]    startReg,
  output logic [PC_W-1:0]    endReg,
  output logic [K_W:0]       cntReg,
  output logic [PC_W-1:0]    retReg
);

  localparam int CNT_W = K_W + 1;
  localparam logic [PC_W-1:0] INVALID = '1;

  logic [PC_W-1:0]  pcNext;
  logic [CNT_W-1:0] cntLoad;

  assign pcNext  = pc + PC_W'(1);
  assign cntLoad = CNT_W'(kField) + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= INVALID;
      endReg   <= INVALID;
    end else if (strobe.loadDo) begin
      startReg <= pcNext;
      endReg   <= pcNext + PC_W'(niField);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobe.loadDo || strobe.loadRedo) begin
      cntReg <= cntLoad;
    end else if (strobe.decCnt) begin
      cntReg <= cntReg - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retReg <= INVALID;
    end else if (strobe.loadRedo) begin
      retReg <= pcNext;
    end else if (strobe.clrRet) begin
      retReg <= INVALID;
    end
  end

  // R6: reset leaves every address invalid and the counter empty
  a_r6_reset_state: assert property (@(posedge clk)
    !rstN |=> (startReg == INVALID && endReg == INVALID && retReg == INVALID && cntReg == '0));

  // R2: a capture stores the body bounds and the repeat count
  a_r2_do_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDo |=> (startReg == $past(pc) + PC_W'(1)) &&
                      (endReg == $past(pc) + PC_W'($past(niField)) + PC_W'(1)) &&
                      (cntReg == CNT_W'($past(kField)) + CNT_W'(1)));

  // R4: each loop-back removes exactly one iteration
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decCnt && !strobe.loadDo && !strobe.loadRedo) |=> cntReg == $past(cntReg) - CNT_W'(1));

  // R5: a consumed return address becomes invalid
  a_r5_ret_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrRet && !strobe.loadRedo) |=> retReg == INVALID);

  // R8: with no strobe the loop state holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(startReg) && $stable(endReg) && $stable(cntReg) && $stable(retReg)));

endmodule

// File: rtl/loop_cache_ctrl.sv
module loop_cache_ctrl
  import loop_cache_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7,
  parameter int OPC_W = 5,
  parameter logic [OPC_W-1:0] LOOP_OPC = 5'h0E
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instValid,
  input  logic [PC_W-1:0]        pc,
  input  logic [PC_W-1:0]        opcode,
  input  logic [1:0]             baseAdvance,
  input  logic [1:0]             baseCycles,
  input  logic [PC_W-1:0]        startReg,
  input  logic [PC_W-1:0]        endReg,
  input  logic [K_W:0]           cntReg,
  input  logic [PC_W-1:0]        retReg,
  output logic [NI_W-1:0]        niField,
  output logic [K_W-1:0]         kField,
  output loop_strobe_t           strobe,
  output logic signed [PC_W-1:0] pcAdvance,
  output logic [PC_W-1:0]        nextPc,
  output logic [1:0]             cycleCost
);

  localparam int CNT_W = K_W + 1;
  localparam int OPC_LSB = NI_W + K_W;
  localparam logic [PC_W-1:0] INVALID = '1;

  logic             isLoop, isDo, isRedo;
  logic             startValid, retValid, effEndValid;
  logic [PC_W-1:0]  effStart, effEnd;
  logic [CNT_W-1:0] effCnt;
  logic [PC_W-1:0]  stepAdv, seqPc;
  logic             atEnd, loopBack, retJump;
  logic [PC_W-1:0]  advance;

  // Instruction field decode
  always_comb begin
    isLoop  = opcode[OPC_LSB +: OPC_W] == LOOP_OPC;
    niField = opcode[K_W +: NI_W];
    kField  = opcode[K_W-1:0];
  end

  // Capture/replay classification
  always_comb begin
    startValid = startReg != INVALID;
    retValid   = retReg != INVALID;
    isDo       = isLoop && (niField != '0);
    isRedo     = isLoop && (niField == '0) && startValid;
  end

  // Loop state as seen after this instruction's own load
  always_comb begin
    effStart    = isDo ? pc + PC_W'(1) : startReg;
    effEnd      = isDo ? pc + PC_W'(niField) + PC_W'(1) : endReg;
    effEndValid = effEnd != INVALID;
    effCnt      = (isDo || isRedo) ? CNT_W'(kField) + CNT_W'(1) : cntReg;
  end

  // Step before any end-of-loop redirection
  always_comb begin
    if (isRedo) begin
      stepAdv   = startReg - pc;
      cycleCost = 2'd2;
    end else if (isLoop) begin
      stepAdv   = PC_W'(1);
      cycleCost = 2'd1;
    end else begin
      stepAdv   = PC_W'(baseAdvance);
      cycleCost = baseCycles;
    end
    seqPc = pc + stepAdv;
  end

  // End-of-loop handling
  always_comb begin
    atEnd    = effEndValid && (seqPc == effEnd);
    loopBack = atEnd && (effCnt != '0);
    retJump  = atEnd && (effCnt == '0) && retValid;
    if (loopBack)     advance = effStart - pc;
    else if (retJump) advance = retReg - pc;
    else              advance = stepAdv;
    pcAdvance = signed'(advance);
    nextPc    = pc + advance;
  end

  always_comb begin
    strobe.loadDo   = instValid && isDo;
    strobe.loadRedo = instValid && isRedo;
    strobe.decCnt   = instValid && loopBack;
    strobe.clrRet   = instValid && retJump;
  end

  // R7: a replay without a captured body behaves as a one-cycle no-op
  a_r7_redo_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (isLoop && niField == '0 && startReg == INVALID) |-> (nextPc == pc + PC_W'(1) && cycleCost == 2'd1));

  // R3: an accepted replay costs two cycles
  a_r3_redo_cost: assert property (@(posedge clk) disable iff (!rstN)
    (isLoop && niField == '0 && startReg != INVALID && cntReg == '0) |-> cycleCost == 2'd2);

  // R4: a plain instruction reaching the loop end with iterations left goes to the loop start
  a_r4_loop_target: assert property (@(posedge clk) disable iff (!rstN)
    (!isLoop && cntReg != '0 && pc + PC_W'(baseAdvance) == endReg) |-> nextPc == startReg);

  // R5: a loop end with no iterations left and no return address falls through
  a_r5_fall_through: assert property (@(posedge clk) disable iff (!rstN)
    (!isLoop && cntReg == '0 && retReg == INVALID) |-> nextPc == pc + PC_W'(baseAdvance));

endmodule

// File: rtl/loop_cache_seq.sv
module loop_cache_seq
  import loop_cache_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int NI_W = 4,
  parameter int K_W  = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instValid,
  input  logic [PC_W-1:0]        pc,
  input  logic [PC_W-1:0]        opcode,
  input  logic [1:0]             baseAdvance,
  input  logic [1:0]             baseCycles,
  output logic signed [PC_W-1:0] pcAdvance,
  output logic [PC_W-1:0]        nextPc,
  output logic [1:0]             cycleCost,
  output logic                   loopActive
);

  loop_strobe_t    strobe;
  logic [NI_W-1:0] niField;
  logic [K_W-1:0]  kField;
  logic [PC_W-1:0] startReg, endReg, retReg;
  logic [K_W:0]    cntReg;

  loop_cache_ctrl #(.PC_W(PC_W), .NI_W(NI_W), .K_W(K_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .pc(pc), .opcode(opcode),
    .baseAdvance(baseAdvance), .baseCycles(baseCycles),
    .startReg(startReg), .endReg(endReg), .cntReg(cntReg), .retReg(retReg),
    .niField(niField), .kField(kField), .strobe(strobe),
    .pcAdvance(pcAdvance), .nextPc(nextPc), .cycleCost(cycleCost)
  );

  loop_cache_regs #(.PC_W(PC_W), .NI_W(NI_W), .K_W(K_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pc(pc),
    .niField(niField), .kField(kField),
    .startReg(startReg), .endReg(endReg), .cntReg(cntReg), .retReg(retReg)
  );

  assign loopActive = cntReg != '0;  // R9

endmodule

// File: tb/loop_cache_seq_bench.sv
`timescale 1ns/100ps
module loop_cache_seq_bench;

  localparam logic [15:0] INV = 16'hFFFF;
  localparam logic [15:0] NOP = 16'h0000;

  typedef struct {
    logic [15:0] adv;
    logic [15:0] npc;
    logic [1:0]  cyc;
    logic        act;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] opcode = '0;
  logic [1:0]  baseAdvance = 2'd1;
  logic [1:0]  baseCycles = 2'd1;
  logic signed [15:0] pcAdvance;
  logic [15:0] nextPc;
  logic [1:0]  cycleCost;
  logic        loopActive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t expQ[$];

  // Bench model of the loop state
  logic [15:0] mStart = INV, mEnd = INV, mRet = INV, mPc = '0;
  logic [7:0]  mCnt = '0;

  always #2.5 clk = ~clk;

  loop_cache_seq u_loop_cache_seq (
    .clk(clk), .rstN(rstN), .instValid(instValid), .pc(pc), .opcode(opcode),
    .baseAdvance(baseAdvance), .baseCycles(baseCycles),
    .pcAdvance(pcAdvance), .nextPc(nextPc), .cycleCost(cycleCost), .loopActive(loopActive)
  );

  function automatic logic [15:0] loopOp(int ni, int k);
    return 16'h7000 | 16'((ni & 15) << 7) | 16'(k & 127);
  endfunction

  task automatic exec(logic [15:0] op, int bAdv, int bCyc, string tag);
    logic [15:0] adv, nS, nE, nR;
    logic [7:0]  nC;
    logic [1:0]  cyc;
    logic        isL;
    int          ni;
    exp_t        e;
    @(negedge clk);
    isL = op[15:11] == 5'h0E;
    ni  = int'(op[10:7]);
    adv = 16'(bAdv); cyc = 2'(bCyc);
    nS = mStart; nE = mEnd; nC = mCnt; nR = mRet;
    if (isL) begin
      adv = 16'd1; cyc = 2'd1;
      if (ni != 0) begin
        nS = mPc + 16'd1; nE = mPc + 16'(ni) + 16'd1; nC = 8'(op[6:0]) + 8'd1;
      end else if (mStart != INV) begin
        nC = 8'(op[6:0]) + 8'd1; nR = mPc + 16'd1; adv = mStart - mPc; cyc = 2'd2;
      end
    end
    if (nE != INV && mPc + adv == nE) begin
      if (nC != 0) begin
        nC = nC - 8'd1; adv = nS - mPc;
      end else if (nR != INV) begin
        adv = nR - mPc; nR = INV;
      end
    end
    e.adv = adv; e.npc = mPc + adv; e.cyc = cyc; e.act = (mCnt != 0); e.tag = tag;
    pc = mPc; opcode = op; baseAdvance = 2'(bAdv); baseCycles = 2'(bCyc); instValid = 1'b1;
    expQ.push_back(e);
    mStart = nS; mEnd = nE; mCnt = nC; mRet = nR; mPc = mPc + adv;
  endtask

  task automatic stall(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instValid = 1'b0;
      opcode = NOP;
    end
  endtask

  // Monitor: compares design outputs with queued expectations before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() != 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (pcAdvance != e.adv || nextPc != e.npc || cycleCost != e.cyc || loopActive != e.act) begin
          failures++;
          $display("FAIL %s pc=%h: adv=%h npc=%h cyc=%0d act=%0b expected adv=%h npc=%h cyc=%0d act=%0b",
                   e.tag, pc, pcAdvance, nextPc, cycleCost, loopActive, e.adv, e.npc, e.cyc, e.act);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R6/R7: after reset no body is captured, so a replay is a one-cycle no-op
    mPc = 16'h0010;
    exec(loopOp(0, 3), 1, 1, "R6 R7 replay after reset");
    exec(NOP, 1, 1, "R7 R9 no loop started");
    // R2/R4: capture of three instructions, repeat 1, stalled mid-loop
    mPc = 16'h0020;
    exec(loopOp(3, 1), 1, 1, "R2 capture");
    for (int i = 0; i < 4; i++) exec(NOP, 1, 1, "R4 R9 body pass");
    stall(3);
    for (int i = 0; i < 5; i++) exec(NOP, 1, 1, "R8 R4 body after stall");
    // R3/R5: replay with repeat 0, then return after the replay
    exec(loopOp(0, 0), 1, 1, "R3 replay jump");
    for (int i = 0; i < 6; i++) exec(NOP, 1, 1, "R5 replay body and return");
    exec(NOP, 1, 1, "R5 after return");
    // R4: single-instruction body, repeat 2
    exec(loopOp(1, 2), 1, 1, "R2 one-word body capture");
    for (int i = 0; i < 5; i++) exec(NOP, 1, 1, "R4 single body");
    // R10: fifteen-word body walked with two-word instructions
    exec(loopOp(15, 0), 1, 1, "R2 full body capture");
    for (int i = 0; i < 16; i++) exec(NOP, 2, 2, "R10 two-word body");
    // R1: ordinary instruction uses base advance and cost
    exec(NOP, 2, 3, "R1 pass-through");
    exec(16'h6FFF, 1, 2, "R1 non-loop opcode class");
    @(negedge clk);
    instValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule